// File: doc/BRIEF.md
# Slotted Broadcast Status Responder

This block lives in every distributed I/O node on a shared packet bus. A broadcast query from the host marks the start of a control cycle. Each node then holds back for a slot that grows with its own node number, after which it issues its local status word as a broadcast write. Node numbers are unique, begin at 0 and have no gaps, so every node gets a time window of its own.

Every node also listens to the status broadcasts of its peers and keeps them in a local table, one entry per node, each with a valid flag. The flags are cleared by each query, so an entry that was not refreshed in the current cycle shows as stale. A node writes its own entry at the moment it transmits. As a result, the host can gather the status of the whole system with a single read from any one node, once it has waited one slot for each node. After the status phase, the host sends one broadcast command, which every node accepts and passes on.

Slot length is `SLOT_US` microseconds, counted in clock cycles through the parameter `CLK_PER_US`.

Top module: `slot_status_responder`

## Requirements
- R1: After reset, `tx_valid` and `cmd_valid` are 0 and `rd_valid` is 0 for every table index.
- R2: A query is a cycle with `rx_valid`=1 and `rx_kind`=1. If the query is presented in cycle c, `tx_valid` is 1 for exactly one cycle, in cycle c+1+D, where D = SLOT_US*CLK_PER_US*`node_id`. For node 0 this is the cycle right after the query.
- R3: In the cycle where `tx_valid` is 1, `tx_src` equals `node_id` and `tx_data` equals the `local_status` value present in the cycle before.
- R4: A status packet (`rx_valid`=1, `rx_kind`=2) writes `rx_data` into entry `rx_src` and sets that entry's valid flag. The read port (`rd_idx` to `rd_data`/`rd_valid`, combinational) shows the new contents from the next cycle on.
- R5: A query clears every valid flag. From the next cycle on, entries not written since the query read with `rd_valid`=0.
- R6: When a node transmits, its own entry `node_id` holds the transmitted status and is valid in the same cycle that `tx_valid` is 1.
- R7: A query that arrives while a slot is still pending restarts the delay from the newer query. Only one transmission follows.
- R8: A command packet (`rx_valid`=1, `rx_kind`=3) gives `cmd_valid`=1 for one cycle, in the next cycle, with `cmd_data` equal to its `rx_data`. It does not change the table.
- R9: Packets with `rx_kind`=0, and any cycle with `rx_valid`=0, have no effect on the table, on transmission or on `cmd_valid`.
- R10: If a peer status packet for this node's own index arrives in the same cycle that the node writes its own entry, the node's own status is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received packet is present this cycle |
| rx_kind | input | 2 | Packet kind: 0 other, 1 query, 2 status, 3 command |
| rx_src | input | NODE_W (6) | Sender node number of a status packet |
| rx_data | input | STAT_W (32) | Packet payload |
| node_id | input | NODE_W (6) | This node's number |
| local_status | input | STAT_W (32) | This node's current status word |
| tx_valid | output | 1 | One-cycle transmit request for the status broadcast |
| tx_src | output | NODE_W (6) | Node number carried by the broadcast |
| tx_data | output | STAT_W (32) | Status word carried by the broadcast |
| cmd_valid | output | 1 | One-cycle pulse for an accepted host command |
| cmd_data | output | STAT_W (32) | Command payload |
| rd_idx | input | NODE_W (6) | Table read index |
| rd_data | output | STAT_W (32) | Table entry at `rd_idx` |
| rd_valid | output | 1 | Valid flag of the entry at `rd_idx` |

## Verification
The slot timing is tried with node numbers 0, 1, 5 and 63. These separate a zero-delay transmit from a one-slot delay, a multi-slot delay and the largest count, and the exact cycle of each pulse exposes any off-by-one in the counter. Each of these cycles is bracketed by a peer status write and the following query, which shows that the write lands and that the clear hits only stale entries. Directed cases then retrigger a pending slot, collide a peer write with the node's own write, and send command, other-kind and not-valid packets, confirming that only the intended state moves.

// File: rtl/slot_status_pkg.sv
package slot_status_pkg;
    typedef enum logic [1:0] {
        PK_OTHER  = 2'd0,
        PK_QUERY  = 2'd1,
        PK_STATUS = 2'd2,
        PK_CMD    = 2'd3
    } pkt_kind_e;
endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int NODES      = 64,
    parameter int CLK_PER_US = 125,
    parameter int SLOT_US    = 5,
    localparam int NODE_W    = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NODE_W-1:0] node_id,
    output logic              fire
);
    localparam int SLOT_CYC = SLOT_US * CLK_PER_US;
    localparam int MAX_DLY  = SLOT_CYC * (NODES - 1);
    localparam int CNT_W    = (MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             s_d, s_q;
    logic [CNT_W-1:0] dly;

    always_comb begin
        dly  = CNT_W'(SLOT_CYC) * CNT_W'(node_id);
        s_d  = s_q;
        fire = 1'b0;
        if (start) begin
            if (dly == '0) begin
                fire     = 1'b1;
                s_d.armed = 1'b0;
                s_d.cnt   = '0;
            end else begin
                s_d.armed = 1'b1;
                s_d.cnt   = dly - CNT_W'(1);
            end
        end else if (s_q.armed) begin
            if (s_q.cnt == '0) begin
                fire      = 1'b1;
                s_d.armed = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: one slot yields a single event unless a new query restarts it
    assert_single_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!fire || start));

    // R2: node 0 fires in the query cycle itself
    assert_zero_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && node_id == '0) |-> fire);

    // R2: no event while a nonzero count is still running
    assert_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.armed && s_q.cnt != '0 && !start) |-> !fire);
endmodule

// File: rtl/status_table.sv
module status_table #(
    parameter int NODES   = 64,
    parameter int STAT_W  = 32,
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pw_en,
    input  logic [NODE_W-1:0] pw_idx,
    input  logic [STAT_W-1:0] pw_data,
    input  logic              ow_en,
    input  logic [NODE_W-1:0] ow_idx,
    input  logic [STAT_W-1:0] ow_data,
    input  logic [NODE_W-1:0] rd_idx,
    output logic [STAT_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic [NODES-1:0]             vld;
        logic [NODES-1:0][STAT_W-1:0] data;
    } tbl_t;

    tbl_t             s_d, s_q;
    logic [NODES-1:0] sel_peer, sel_own;

    for (genvar g = 0; g < NODES; g++) begin : g_sel
        assign sel_peer[g] = pw_en && (pw_idx == NODE_W'(g));
        assign sel_own[g]  = ow_en && (ow_idx == NODE_W'(g));
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NODES; i++) begin
            if (clr) s_d.vld[i] = 1'b0;
            if (sel_own[i]) begin
                s_d.vld[i]  = 1'b1;
                s_d.data[i] = ow_data;
            end else if (sel_peer[i]) begin
                s_d.vld[i]  = 1'b1;
                s_d.data[i] = pw_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data  = s_q.data[rd_idx];
    assign rd_valid = s_q.vld[rd_idx];

    // R5: a clear without an own write leaves no valid entry
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ow_en) |=> (s_q.vld == '0));

    // R4: a peer write that is not overridden lands in its entry
    assert_peer_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en && !(ow_en && ow_idx == pw_idx))
        |=> (s_q.vld[$past(pw_idx)] && s_q.data[$past(pw_idx)] == $past(pw_data)));

    // R6 and R10: the own write always wins its entry
    assert_own_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ow_en |=> (s_q.vld[$past(ow_idx)] && s_q.data[$past(ow_idx)] == $past(ow_data)));
endmodule

// File: rtl/slot_status_responder.sv
module slot_status_responder
    import slot_status_pkg::*;
#(
    parameter int NODES      = 64,
    parameter int STAT_W     = 32,
    parameter int CLK_PER_US = 125,
    parameter int SLOT_US    = 5,
    localparam int NODE_W    = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [1:0]        rx_kind,
    input  logic [NODE_W-1:0] rx_src,
    input  logic [STAT_W-1:0] rx_data,
    input  logic [NODE_W-1:0] node_id,
    input  logic [STAT_W-1:0] local_status,
    output logic              tx_valid,
    output logic [NODE_W-1:0] tx_src,
    output logic [STAT_W-1:0] tx_data,
    output logic              cmd_valid,
    output logic [STAT_W-1:0] cmd_data,
    input  logic [NODE_W-1:0] rd_idx,
    output logic [STAT_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic              tx_valid;
        logic [NODE_W-1:0] tx_src;
        logic [STAT_W-1:0] tx_data;
        logic              cmd_valid;
        logic [STAT_W-1:0] cmd_data;
    } out_t;

    out_t s_d, s_q;
    logic is_query, is_status, is_cmd, fire;

    assign is_query  = rx_valid && (rx_kind == PK_QUERY);
    assign is_status = rx_valid && (rx_kind == PK_STATUS);
    assign is_cmd    = rx_valid && (rx_kind == PK_CMD);

    slot_timer #(
        .NODES(NODES), .CLK_PER_US(CLK_PER_US), .SLOT_US(SLOT_US)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(is_query), .node_id(node_id), .fire(fire)
    );

    status_table #(
        .NODES(NODES), .STAT_W(STAT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .clr(is_query),
        .pw_en(is_status), .pw_idx(rx_src), .pw_data(rx_data),
        .ow_en(fire), .ow_idx(node_id), .ow_data(local_status),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always_comb begin
        s_d           = s_q;
        s_d.tx_valid  = fire;
        s_d.cmd_valid = is_cmd;
        if (fire) begin
            s_d.tx_src  = node_id;
            s_d.tx_data = local_status;
        end
        if (is_cmd) s_d.cmd_data = rx_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_valid  = s_q.tx_valid;
    assign tx_src    = s_q.tx_src;
    assign tx_data   = s_q.tx_data;
    assign cmd_valid = s_q.cmd_valid;
    assign cmd_data  = s_q.cmd_data;

    // R8: a command is passed on in the next cycle with its payload
    assert_cmd_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> (cmd_valid && cmd_data == $past(rx_data)));

    // R9: non-command cycles raise no command pulse
    assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cmd |=> !cmd_valid);

    // R3: the broadcast carries the node number and the status of the firing cycle
    assert_tx_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (tx_valid && tx_src == $past(node_id) && tx_data == $past(local_status)));
endmodule

// File: tb/slot_status_responder_test.sv
module slot_status_responder_test;
    localparam int CPU  = 2;
    localparam int SLOT = 5 * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [1:0]  rx_kind = 2'd0;
    logic [5:0]  rx_src = '0;
    logic [31:0] rx_data = '0;
    logic [5:0]  node_id = '0;
    logic [31:0] local_status = '0;
    logic        tx_valid, cmd_valid, rd_valid;
    logic [5:0]  tx_src;
    logic [31:0] tx_data, cmd_data, rd_data;
    logic [5:0]  rd_idx = '0;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    slot_status_responder #(.CLK_PER_US(CPU)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_kind(rx_kind),
        .rx_src(rx_src), .rx_data(rx_data), .node_id(node_id),
        .local_status(local_status), .tx_valid(tx_valid), .tx_src(tx_src),
        .tx_data(tx_data), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    localparam int NV = 4;
    localparam logic [5:0]  VID [NV] = '{6'd0, 6'd1, 6'd5, 6'd63};
    localparam logic [31:0] VST [NV] = '{32'h1111_0000, 32'hA5A5_0001, 32'h0BAD_F00D, 32'hFFFF_0063};
    localparam int          VDLY[NV] = '{0, 10, 50, 630};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_rx(input logic [1:0] kind, input logic [5:0] src, input logic [31:0] data);
        @(negedge clk);
        rx_valid = 1'b1; rx_kind = kind; rx_src = src; rx_data = data;
        @(negedge clk);
        rx_valid = 1'b0; rx_kind = 2'd0;
    endtask

    task automatic wait_tx(output int w);
        w = 0;
        while (!tx_valid && w < 2000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic read_entry(input logic [5:0] idx);
        rd_idx = idx;
        #1;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    endtask

    initial begin
        wait (cyc >= 100000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        finish_run();
    end

    initial begin
        int w;
        logic [5:0] peer;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tx_valid == 1'b0, "R1 tx_valid", 64'(tx_valid), 64'd0);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", 64'(cmd_valid), 64'd0);
        read_entry(6'd0);
        chk(rd_valid == 1'b0, "R1 entry 0", 64'(rd_valid), 64'd0);
        read_entry(6'd63);
        chk(rd_valid == 1'b0, "R1 entry 63", 64'(rd_valid), 64'd0);

        // vector table: slot timing, payload, store and clear
        for (int v = 0; v < NV; v++) begin
            node_id = VID[v];
            local_status = VST[v];
            peer = VID[v] + 6'd1;
            put_rx(2'd2, peer, ~VST[v]);
            read_entry(peer);
            chk(rd_valid && rd_data == ~VST[v], "R4 peer store", {31'd0, rd_valid, rd_data}, {32'd1, ~VST[v]});
            put_rx(2'd1, 6'd0, 32'd0);
            read_entry(peer);
            if (VDLY[v] != 0)
                chk(rd_valid == 1'b0, "R5 clear", 64'(rd_valid), 64'd0);
            wait_tx(w);
            chk(w == VDLY[v], "R2 slot delay", 64'(w), 64'(VDLY[v]));
            chk(tx_src == VID[v], "R3 tx_src", 64'(tx_src), 64'(VID[v]));
            chk(tx_data == VST[v], "R3 tx_data", 64'(tx_data), 64'(VST[v]));
            read_entry(VID[v]);
            chk(rd_valid && rd_data == VST[v], "R6 own entry", {31'd0, rd_valid, rd_data}, {32'd1, VST[v]});
            @(negedge clk);
            chk(tx_valid == 1'b0, "R2 single-cycle pulse", 64'(tx_valid), 64'd0);
        end

        // R7 retrigger while pending
        node_id = 6'd3;
        local_status = 32'h3333_3333;
        put_rx(2'd1, 6'd0, 32'd0);
        w = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tx_valid) w++;
        end
        chk(w == 0, "R7 no early tx", 64'(w), 64'd0);
        put_rx(2'd1, 6'd0, 32'd0);
        wait_tx(w);
        chk(w == 3 * SLOT, "R7 delay from newer query", 64'(w), 64'(3 * SLOT));
        w = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tx_valid) w++;
        end
        chk(w == 0, "R7 single transmission", 64'(w), 64'd0);

        // R8 command pass-through, table untouched
        read_entry(6'd3);
        put_rx(2'd3, 6'd3, 32'hC0DE_0001);
        chk(cmd_valid && cmd_data == 32'hC0DE_0001, "R8 command", {31'd0, cmd_valid, cmd_data}, {32'd1, 32'hC0DE_0001});
        #1;
        chk(rd_valid && rd_data == 32'h3333_3333, "R8 table unchanged", {31'd0, rd_valid, rd_data}, {32'd1, 32'h3333_3333});
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R8 command pulse ends", 64'(cmd_valid), 64'd0);

        // R9 ignored packets
        node_id = 6'd0;
        put_rx(2'd2, 6'd7, 32'h0000_AAAA);
        put_rx(2'd0, 6'd7, 32'h0000_BBBB);
        @(negedge clk);
        rx_valid = 1'b0; rx_kind = 2'd2; rx_src = 6'd7; rx_data = 32'h0000_CCCC;
        @(negedge clk);
        rx_kind = 2'd1;
        @(negedge clk);
        rx_kind = 2'd3;
        @(negedge clk);
        rx_kind = 2'd0;
        read_entry(6'd7);
        chk(rd_valid && rd_data == 32'h0000_AAAA, "R9 entry kept", {31'd0, rd_valid, rd_data}, {32'd1, 32'h0000_AAAA});
        w = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_valid || cmd_valid) w++;
        end
        chk(w == 0, "R9 no tx or command", 64'(w), 64'd0);

        // R10 own write beats a colliding peer write
        node_id = 6'd1;
        local_status = 32'h0101_0101;
        put_rx(2'd1, 6'd0, 32'd0);
        repeat (SLOT - 2) @(negedge clk);
        put_rx(2'd2, 6'd1, 32'hDEAD_0001);
        chk(tx_valid == 1'b1, "R10 collision cycle", 64'(tx_valid), 64'd1);
        read_entry(6'd1);
        chk(rd_valid && rd_data == 32'h0101_0101, "R10 own wins", {31'd0, rd_valid, rd_data}, {32'd1, 32'h0101_0101});

        finish_run();
    end
endmodule